// File: doc/BRIEF.md
# Banked Window Memory Self-Test Sequencer

This block is a built-in self-test engine for a buffer memory that is reached through a small window. The memory is split into banks, and a bank-select register chooses which bank the window shows. After a start request the engine makes four passes over every bank, in this order:

1. It writes a counting pattern.
2. It reads the pattern back and compares it.
3. It clears every word to zero.
4. It reads every word back and confirms that each one is zero.

The engine drives a bank-select write port and a 16-bit word port with a write strobe and a read strobe. Read data returns one cycle after the read strobe.

When the test ends, the engine pulses `done` for one cycle and holds a `pass` flag. If a word compares wrong, the engine stops at that word. It holds the bank, the word offset, the value read and the value expected, and keeps them until the next start. The number of banks, the window depth in words, the data width and the per-bank seed step are all parameters. The defaults are 8 banks of 4096 words and a step of 0x1000.

Top module: `bank_window_bist`

## Requirements
- R1: A high `start` while the engine is idle begins a run. A `start` during a run has no effect on the run, its length or its result.
- R2: Before the first access to bank i in every pass, the engine makes a one-cycle `bsel_wr` with `bsel_bank` = i and `bsel_en` = 1. The words of that bank are then accessed in consecutive cycles at `mem_addr` 0, 1, ..., WORDS-1, and no access happens in the select cycle.
- R3: The passes run in this order: pattern write, pattern check, zero fill, zero check. Within each pass the banks are taken in ascending order.
- R4: The pattern word at offset j of bank i is (i * SEED_STEP + j) modulo 2^DATA_W. The default SEED_STEP is 0x1000.
- R5: `mem_we` and `mem_re` are never high together. `mem_rdata` is compared in the cycle after the matching `mem_re`.
- R6: A mismatch in a check pass ends the run. There is no memory access and no bank select from the cycle in which the bad word returns. `done` rises in the next cycle with `pass` = 0.
- R7: The zero fill writes 0 to every word of every bank. The zero check fails on any nonzero word, including a word that held a correct pattern.
- R8: `done` is high for exactly one cycle. On a clean run, `done` is high in cycle 4*BANKS*(WORDS+1)+2, counting the first cycle after the start edge as cycle 1, and `pass` = 1.
- R9: On a failure, `fail_bank`, `fail_offset`, `fail_read` and `fail_expect` hold the first failing word. These fields and `pass` keep their values until the next accepted start, which clears them to 0.
- R10: While reset is asserted and right after it, `done`, `pass`, `bsel_wr`, `mem_we`, `mem_re` and all failure fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled while idle |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Held result of the last run |
| bsel_wr | output | 1 | Bank-select register write strobe |
| bsel_bank | output | BW | Bank index to select |
| bsel_en | output | 1 | Window enable bit written with the bank |
| mem_addr | output | AW | Word offset in the window |
| mem_we | output | 1 | Word write strobe |
| mem_re | output | 1 | Word read strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after `mem_re` |
| fail_bank | output | BW | Bank of the first failing word |
| fail_offset | output | AW | Offset of the first failing word |
| fail_read | output | DATA_W | Value read at the failing word |
| fail_expect | output | DATA_W | Value expected at the failing word |

## Verification
The bench runs the engine against a memory model into which one fault at a time is injected.

- A fault-free memory shows that the run completes, that its length is exact, and that the write stream is correct.
- A bit forced high that clashes with the pattern is caught in the pattern check.
- A bit forced high that agrees with the pattern escapes the pattern check and is caught only by the zero check.
- A cell that keeps its first write passes the pattern check and fails only after the clear.
- A bank decoder that drops an index bit lets a later bank overwrite an earlier one, so the failure is reported at bank 0, offset 0.
- Bits forced low in the first and last banks show that the stop happens at the first bad word and that the captured fields are right.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  typedef enum logic [1:0] {
    PH_WRPAT   = 2'd0,
    PH_CHKPAT  = 2'd1,
    PH_CLEAR   = 2'd2,
    PH_CHKZERO = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_ACC  = 2'd2,
    ST_FIN  = 2'd3
  } state_e;

endpackage

// File: rtl/bwb_walker.sv
// Phase / bank / word position counters for the test sweep.
module bwb_walker
  import bwb_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int WORDS = 4096,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [BW-1:0] bank,
  output logic [AW-1:0] word,
  output phase_e        phase,
  output logic          last_word,
  output logic          last_bank,
  output logic          last_phase
);

  localparam logic [BW-1:0] BANK_MAX = BW'(BANKS - 1);
  localparam logic [AW-1:0] WORD_MAX = AW'(WORDS - 1);

  logic [BW-1:0] bank_d;
  logic [AW-1:0] word_d;
  phase_e        phase_d;
  logic [1:0]    phase_inc;
  logic          pos_en;

  assign last_word  = (word == WORD_MAX);
  assign last_bank  = (bank == BANK_MAX);
  assign last_phase = (phase == PH_CHKZERO);
  assign phase_inc  = phase + 2'd1;
  assign pos_en     = clr | step;

  always_comb begin
    bank_d  = bank;
    word_d  = word;
    phase_d = phase;
    if (clr) begin
      bank_d  = '0;
      word_d  = '0;
      phase_d = PH_WRPAT;
    end else if (step) begin
      if (last_word) begin
        word_d = '0;
        if (last_bank) begin
          bank_d  = '0;
          phase_d = phase_e'(phase_inc);
        end else begin
          bank_d = bank + 1'b1;
        end
      end else begin
        word_d = word + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank  <= '0;
      word  <= '0;
      phase <= PH_WRPAT;
    end else if (pos_en) begin
      bank  <= bank_d;
      word  <= word_d;
      phase <= phase_d;
    end
  end

endmodule

// File: rtl/bwb_pattern.sv
// Expected data and access direction for the current sweep position.
module bwb_pattern
  import bwb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEED_STEP = 'h1000,
  parameter int BW        = 3,
  parameter int AW        = 12
) (
  input  phase_e            phase,
  input  logic [BW-1:0]     bank,
  input  logic [AW-1:0]     word,
  output logic [DATA_W-1:0] expect_o,
  output logic              is_write,
  output logic              is_read
);

  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(SEED_STEP);

  logic [DATA_W-1:0] seed;
  logic              patterned;

  assign seed      = DATA_W'(bank) * STEP_V;
  assign patterned = (phase == PH_WRPAT) || (phase == PH_CHKPAT);
  assign is_write  = (phase == PH_WRPAT) || (phase == PH_CLEAR);
  assign is_read   = !is_write;
  assign expect_o  = patterned ? (seed + DATA_W'(word)) : '0;

endmodule

// File: rtl/bwb_compare.sv
// One-stage read compare: holds the issued position, compares returning data.
module bwb_compare #(
  parameter int DATA_W = 16,
  parameter int BW     = 3,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [BW-1:0]     bank_i,
  input  logic [AW-1:0]     word_i,
  input  logic [DATA_W-1:0] expect_i,
  input  logic [DATA_W-1:0] rdata,
  output logic              bad,
  output logic [BW-1:0]     bank_q,
  output logic [AW-1:0]     word_q,
  output logic [DATA_W-1:0] expect_q
);

  logic vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
    end else begin
      vld <= issue;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= '0;
      word_q   <= '0;
      expect_q <= '0;
    end else if (issue) begin
      bank_q   <= bank_i;
      word_q   <= word_i;
      expect_q <= expect_i;
    end
  end

  assign bad = vld && (rdata != expect_q);

endmodule

// File: rtl/bank_window_bist.sv
// Banked window memory self-test sequencer (top).
module bank_window_bist
  import bwb_pkg::*;
#(
  parameter int BANKS     = 8,
  parameter int WORDS     = 4096,
  parameter int DATA_W    = 16,
  parameter int SEED_STEP = 'h1000,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic              bsel_wr,
  output logic [BW-1:0]     bsel_bank,
  output logic              bsel_en,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [BW-1:0]     fail_bank,
  output logic [AW-1:0]     fail_offset,
  output logic [DATA_W-1:0] fail_read,
  output logic [DATA_W-1:0] fail_expect
);

  // reset: asserted asynchronously, released through two flops
  logic rst_q1, rst_q2, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign srst_n = rst_q2;

  state_e            st, st_d;
  logic [BW-1:0]     pos_bank;
  logic [AW-1:0]     pos_word;
  phase_e            pos_phase;
  logic              last_word, last_bank, last_phase;
  logic [DATA_W-1:0] exp_now;
  logic              is_write, is_read;
  logic              cmp_bad;
  logic [BW-1:0]     cmp_bank;
  logic [AW-1:0]     cmp_word;
  logic [DATA_W-1:0] cmp_exp;
  logic              start_go, running, fail_hit, finish_ok, access;

  assign start_go  = (st == ST_IDLE) && start;
  assign running   = (st != ST_IDLE);
  assign fail_hit  = running && cmp_bad;
  assign finish_ok = (st == ST_FIN) && !cmp_bad;
  assign access    = (st == ST_ACC) && !cmp_bad;

  bwb_walker #(
    .BANKS (BANKS),
    .WORDS (WORDS)
  ) u_walk (
    .clk        (clk),
    .rst_n      (srst_n),
    .clr        (start_go),
    .step       (access),
    .bank       (pos_bank),
    .word       (pos_word),
    .phase      (pos_phase),
    .last_word  (last_word),
    .last_bank  (last_bank),
    .last_phase (last_phase)
  );

  bwb_pattern #(
    .DATA_W    (DATA_W),
    .SEED_STEP (SEED_STEP),
    .BW        (BW),
    .AW        (AW)
  ) u_pat (
    .phase    (pos_phase),
    .bank     (pos_bank),
    .word     (pos_word),
    .expect_o (exp_now),
    .is_write (is_write),
    .is_read  (is_read)
  );

  bwb_compare #(
    .DATA_W (DATA_W),
    .BW     (BW),
    .AW     (AW)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (srst_n),
    .issue    (mem_re),
    .bank_i   (pos_bank),
    .word_i   (pos_word),
    .expect_i (exp_now),
    .rdata    (mem_rdata),
    .bad      (cmp_bad),
    .bank_q   (cmp_bank),
    .word_q   (cmp_word),
    .expect_q (cmp_exp)
  );

  // sequencer next state
  always_comb begin
    st_d = st;
    unique case (st)
      ST_IDLE: if (start) st_d = ST_SEL;
      ST_SEL:  st_d = cmp_bad ? ST_IDLE : ST_ACC;
      ST_ACC: begin
        if (cmp_bad) begin
          st_d = ST_IDLE;
        end else if (last_word) begin
          st_d = (last_bank && last_phase) ? ST_FIN : ST_SEL;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st <= ST_IDLE;
    end else begin
      st <= st_d;
    end
  end

  // port drive
  assign bsel_wr   = (st == ST_SEL) && !cmp_bad;
  assign bsel_bank = pos_bank;
  assign bsel_en   = 1'b1;
  assign mem_addr  = pos_word;
  assign mem_we    = access && is_write;
  assign mem_re    = access && is_read;
  assign mem_wdata = is_write ? exp_now : '0;

  // result registers
  logic              done_d, pass_d, pass_en, fail_en;
  logic [BW-1:0]     fbank_d;
  logic [AW-1:0]     foff_d;
  logic [DATA_W-1:0] fread_d, fexp_d;

  assign done_d  = fail_hit || finish_ok;
  assign pass_en = start_go || fail_hit || finish_ok;
  assign pass_d  = finish_ok;
  assign fail_en = start_go || fail_hit;

  always_comb begin
    if (start_go) begin
      fbank_d = '0;
      foff_d  = '0;
      fread_d = '0;
      fexp_d  = '0;
    end else begin
      fbank_d = cmp_bank;
      foff_d  = cmp_word;
      fread_d = mem_rdata;
      fexp_d  = cmp_exp;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done <= 1'b0;
    end else begin
      done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pass <= 1'b0;
    end else if (pass_en) begin
      pass <= pass_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fail_bank   <= '0;
      fail_offset <= '0;
      fail_read   <= '0;
      fail_expect <= '0;
    end else if (fail_en) begin
      fail_bank   <= fbank_d;
      fail_offset <= foff_d;
      fail_read   <= fread_d;
      fail_expect <= fexp_d;
    end
  end

endmodule

// File: rtl/bank_window_bist_chk.sv
module bank_window_bist_chk #(
  parameter int AW     = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              pass,
  input logic              bsel_wr,
  input logic              bsel_en,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [DATA_W-1:0] fail_read
);

  logic acc;
  logic sel_seen;

  assign acc = mem_we || mem_re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_seen <= 1'b0;
    end else if (done) begin
      sel_seen <= 1'b0;
    end else if (bsel_wr && bsel_en) begin
      sel_seen <= 1'b1;
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_pass_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> done);

  p_select_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> sel_seen);

  p_word_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && $past(acc)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  p_bank_starts_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bsel_wr) && acc) |-> (mem_addr == '0));

  p_single_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_quiet_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!acc && !bsel_wr));

  p_result_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> ($stable(pass) && $stable(fail_read)));

endmodule

bind bank_window_bist bank_window_bist_chk #(
  .AW     (AW),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .pass      (pass),
  .bsel_wr   (bsel_wr),
  .bsel_en   (bsel_en),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .fail_read (fail_read)
);

// File: tb/bank_window_bist_test.sv
`timescale 1ns/1ps
module bank_window_bist_test;

  localparam int NB = 4;
  localparam int NW = 16;
  localparam int RUN_LEN = 4 * NB * (NW + 1) + 2;

  typedef struct packed {
    logic [2:0]  kind;     // 0 none, 1 force-high, 2 keep-first-write, 3 bank alias, 4 force-low
    logic [1:0]  fbank;
    logic [3:0]  foff;
    logic [15:0] mask;
    logic        e_pass;
    logic [1:0]  e_bank;
    logic [3:0]  e_off;
    logic [15:0] e_read;
    logic [15:0] e_exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd0, 2'd0, 4'd0,  16'h0000, 1'b1, 2'd0, 4'd0,  16'h0000, 16'h0000},
    '{3'd1, 2'd2, 4'd5,  16'h0100, 1'b0, 2'd2, 4'd5,  16'h2105, 16'h2005},
    '{3'd2, 2'd3, 4'd15, 16'h0000, 1'b0, 2'd3, 4'd15, 16'h300F, 16'h0000},
    '{3'd1, 2'd1, 4'd3,  16'h1000, 1'b0, 2'd1, 4'd3,  16'h1000, 16'h0000},
    '{3'd3, 2'd0, 4'd0,  16'h0000, 1'b0, 2'd0, 4'd0,  16'h2000, 16'h0000},
    '{3'd4, 2'd0, 4'd1,  16'h0001, 1'b0, 2'd0, 4'd1,  16'h0000, 16'h0001},
    '{3'd4, 2'd3, 4'd0,  16'h3000, 1'b0, 2'd3, 4'd0,  16'h0000, 16'h3000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        done, pass, bsel_wr, bsel_en, mem_we, mem_re;
  logic [1:0]  bsel_bank, fail_bank;
  logic [3:0]  mem_addr, fail_offset;
  logic [15:0] mem_wdata, mem_rdata, fail_read, fail_expect;

  always #2 clk = ~clk;

  bank_window_bist #(
    .BANKS (NB), .WORDS (NW), .DATA_W (16), .SEED_STEP ('h1000)
  ) uut (
    .clk (clk), .rst_n (rst_n), .start (start), .done (done), .pass (pass),
    .bsel_wr (bsel_wr), .bsel_bank (bsel_bank), .bsel_en (bsel_en),
    .mem_addr (mem_addr), .mem_we (mem_we), .mem_re (mem_re),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .fail_bank (fail_bank), .fail_offset (fail_offset),
    .fail_read (fail_read), .fail_expect (fail_expect)
  );

  // memory model with one injectable fault
  logic [2:0]  f_kind = 3'd0;
  logic [1:0]  f_bank = 2'd0;
  logic [3:0]  f_off  = 4'd0;
  logic [15:0] f_mask = 16'h0;
  logic        held_clr = 1'b0;
  logic        held;
  logic [1:0]  cur_bank;
  logic        cur_en;
  logic [15:0] mem [NB][NW];

  function automatic logic [15:0] rd_val(input logic [1:0] b, input logic [3:0] a);
    logic [15:0] v;
    v = mem[b][a];
    if (b == f_bank && a == f_off) begin
      if (f_kind == 3'd1) v = v | f_mask;
      if (f_kind == 3'd4) v = v & ~f_mask;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (held_clr) held <= 1'b0;
    if (!rst_n) begin
      cur_en <= 1'b0;
    end else begin
      if (bsel_wr) begin
        cur_bank <= (f_kind == 3'd3) ? (bsel_bank & 2'b01) : bsel_bank;
        cur_en   <= bsel_en;
      end
      if (mem_we && cur_en) begin
        if (f_kind == 3'd2 && cur_bank == f_bank && mem_addr == f_off) begin
          if (!held) mem[cur_bank][mem_addr] <= mem_wdata;
          held <= 1'b1;
        end else begin
          mem[cur_bank][mem_addr] <= mem_wdata;
        end
      end
      if (mem_re) mem_rdata <= cur_en ? rd_val(cur_bank, mem_addr) : 16'hFFFF;
    end
  end

  int total = 0;
  int bad = 0;
  int wd = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // results of one run
  int  r_len, r_sels, r_werr, r_extra;
  bit  r_quiet;

  task automatic run(input bit poke);
    int n, k;
    bit last_acc;
    logic [1:0] seen_bank;
    r_len = 0; r_sels = 0; r_werr = 0; r_extra = 0; r_quiet = 1'b0;
    k = 0; last_acc = 1'b0; seen_bank = 2'd0;
    @(negedge clk) held_clr = 1'b1; start = 1'b1;
    n = 0;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      held_clr = 1'b0;
      start = (poke && n == 10);
      if (done) begin
        r_len = n;
        r_quiet = !last_acc && !mem_we && !mem_re && !bsel_wr;
        break;
      end
      if (bsel_wr) begin
        r_sels++;
        seen_bank = bsel_bank;
      end
      if (mem_we) begin
        int kk, eb, ew;
        logic [15:0] ed;
        kk = (k < NB * NW) ? k : k - NB * NW;
        eb = kk / NW;
        ew = kk % NW;
        ed = (k < NB * NW) ? 16'(eb * 'h1000 + ew) : 16'h0;
        if (seen_bank != 2'(eb) || mem_addr != 4'(ew) || mem_wdata != ed) r_werr++;
        k++;
      end
      last_acc = mem_we || mem_re;
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) r_extra++;
    end
  endtask

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    chk("R10 done in reset", done, 0);
    chk("R10 pass in reset", pass, 0);
    chk("R10 no access in reset", {bsel_wr, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 done after reset", done, 0);
    chk("R10 fail fields after reset", {fail_bank, fail_offset, fail_read, fail_expect}, 0);

    // fault table walk
    for (int v = 0; v < 7; v++) begin
      f_kind = VECS[v].kind;
      f_bank = VECS[v].fbank;
      f_off  = VECS[v].foff;
      f_mask = VECS[v].mask;
      run(1'b0);
      chk($sformatf("R7 R8 vec%0d pass", v), pass, VECS[v].e_pass);
      chk($sformatf("R9 vec%0d fail_bank", v), fail_bank, VECS[v].e_bank);
      chk($sformatf("R9 vec%0d fail_offset", v), fail_offset, VECS[v].e_off);
      chk($sformatf("R4 R9 vec%0d fail_read", v), fail_read, VECS[v].e_read);
      chk($sformatf("R4 R9 vec%0d fail_expect", v), fail_expect, VECS[v].e_exp);
      chk($sformatf("R6 vec%0d no access before done", v), r_quiet, 1);
      chk($sformatf("R8 vec%0d single done pulse", v), r_extra, 0);
      chk($sformatf("R2 R3 R4 R7 vec%0d write stream errors", v), r_werr, 0);
      if (v == 0) begin
        chk("R8 clean run length", r_len, RUN_LEN);
        chk("R2 R3 bank selects per run", r_sels, 4 * NB);
      end
    end

    // held result after a failing run (vec6 state) across idle cycles
    repeat (20) @(negedge clk);
    chk("R9 fail_read held while idle", fail_read, 16'h0000);
    chk("R9 fail_expect held while idle", fail_expect, 16'h3000);

    // start during a run is ignored
    f_kind = 3'd0;
    run(1'b1);
    chk("R1 start during run: pass", pass, 1);
    chk("R1 start during run: length", r_len, RUN_LEN);
    chk("R1 start during run: one done", r_extra, 0);
    chk("R9 start clears fail fields", {fail_bank, fail_offset, fail_read, fail_expect}, 0);

    // reset in the middle of a run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-run reset: no access", {bsel_wr, mem_we, mem_re}, 0);
    chk("R10 mid-run reset: done/pass", {done, pass}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle after reset release", {bsel_wr, mem_we, mem_re, done}, 0);
    run(1'b0);
    chk("R1 R8 run after reset passes", pass, 1);
    chk("R8 run after reset length", r_len, RUN_LEN);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule